// File: doc/BRIEF.md
# Prescaled PWM Generator Channel

A single pulse-width modulation channel for fan and power control. An input clock is divided into a time quantum by a two-stage prescaler: an 8-bit linear divider whose result is then stretched by a 4-bit power-of-two shift. A period counter steps once per quantum and wraps after a programmable number of quanta. The output level is active inside a window that opens at a programmable rising point and closes at a programmable falling point. When the two points are equal, the level is active for the whole period.

Software writes two 32-bit registers through a simple write port, selected by `wr_sel`. The control register holds the divider fields and five mode bits: run, pin enable, invert, open-drain and synchronisation disable. The duty register holds the period length and the two window points. Duty-register writes go to a shadow copy. The running copy takes the shadow copy when the period wraps, so a live change never produces a mixed period. Writes can also take effect at once, either because synchronisation is disabled or because the channel is stopped. The channel drives a pin value and a pin output enable, so the pin can be used as a push-pull or an open-drain output.

Top module: `qpwm_channel`

## Requirements
- R1: One quantum lasts ((L+1) << S) clock cycles, where L is control bits [7:0] and S is control bits [11:8].
- R2: A period lasts (P+1) quanta, where P is duty bits [31:24]. Setting the run bit (control bit 16) makes the first cycle after that write the first cycle of quantum 0.
- R3: The rising point R is duty bits [7:0] and the falling point F is duty bits [15:8]. For R<F the level is active in quanta q with R<=q<F. For R>F it is active in quanta q with q>=R or q<F.
- R4: When R equals F, the level is active in every quantum of the period.
- R5: While the run bit is clear, the counters are held at zero and the level is inactive from the cycle after the write, without finishing the current period. Duty writes made while the run bit is clear apply in full once it is set.
- R6: While pin enable (control bit 12) is clear, the pin value is the inactive level, which equals the invert bit.
- R7: The pin value is the level XOR the invert bit (control bit 14). A change of the invert bit shows from the cycle after the write, without waiting for a period boundary.
- R8: With synchronisation enabled (control bit 17 clear) and the channel running, a duty-register write first takes effect in the quantum after the counter wraps from P to 0.
- R9: With control bit 17 set, a duty-register write takes effect from the cycle after the write.
- R10: With open-drain (control bit 13) set, pin_out is 0 and pin_oe is the inverse of the pin value. With it clear, pin_oe is 1 and pin_out is the pin value.
- R11: After reset, all register fields are zero, so pin_out is 0 and pin_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock, also the prescaler input |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the duty register |
| wr_data | input | 32 | Write data |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The hardest situation to reach is a duty-register write that lands in the middle of a running period, where the design must hold the old window until the exact wrap cycle. With synchronisation disabled, the same write must instead show on the next cycle. The bench runs the channel with a one-cycle quantum, so the quantum index is known in every cycle. It then writes at fixed cycle offsets after the run bit is set and checks the expected waveform before and after the write. A second write changes the period length across a wrap, to show that the new length starts exactly at the boundary.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
   localparam int unsigned REG_W          = 32;
   // control register layout
   localparam int unsigned CTL_LIN_LSB    = 0;
   localparam int unsigned CTL_SHIFT_LSB  = 8;
   localparam int unsigned CTL_PIN_BIT    = 12;
   localparam int unsigned CTL_OD_BIT     = 13;
   localparam int unsigned CTL_INV_BIT    = 14;
   localparam int unsigned CTL_RUN_BIT    = 16;
   localparam int unsigned CTL_NOSYNC_BIT = 17;
   // duty register layout
   localparam int unsigned DTY_RISE_LSB   = 0;
   localparam int unsigned DTY_FALL_LSB   = 8;
   localparam int unsigned DTY_PER_LSB    = 24;
   localparam int unsigned FIELD_SPAN     = 8;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_DUTY = 1'b1
   } qpwm_sel_e;
endpackage

// File: rtl/qpwm_prescaler.sv
module qpwm_prescaler #(
   parameter int unsigned LIN_W   = 8,
   parameter int unsigned SHIFT_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [LIN_W-1:0]   lin,
   input  logic [SHIFT_W-1:0] shift,
   output logic               tick
);
   localparam int unsigned MAX_SHIFT = (SHIFT_W == 0) ? 0 : ((1 << SHIFT_W) - 1);
   localparam int unsigned PW        = LIN_W + 1 + MAX_SHIFT;

   logic [PW-1:0] span;
   logic [PW-1:0] limit;
   logic [PW-1:0] pcnt;

   assign span = PW'(lin) + PW'(1);

   generate
      if (SHIFT_W == 0) begin : g_linear_only
         assign limit = span - PW'(1);
      end else begin : g_linear_shift
         assign limit = (span << shift) - PW'(1);
      end
   endgenerate

   // >= keeps the count bounded when the divider shrinks mid-quantum
   assign tick = run && (pcnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (!run) begin
         pcnt <= '0;
      end else if (tick) begin
         pcnt <= '0;
      end else begin
         pcnt <= pcnt + PW'(1);
      end
   end
endmodule

// File: rtl/qpwm_period_engine.sv
module qpwm_period_engine #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             sync_off,
   input  logic             load,
   input  logic [CNT_W-1:0] new_rise,
   input  logic [CNT_W-1:0] new_fall,
   input  logic [CNT_W-1:0] new_per,
   output logic [CNT_W-1:0] q,
   output logic [CNT_W-1:0] cur_rise,
   output logic [CNT_W-1:0] cur_fall,
   output logic [CNT_W-1:0] cur_per,
   output logic             wrap,
   output logic             level
);
   logic [CNT_W-1:0] sh_rise;
   logic [CNT_W-1:0] sh_fall;
   logic [CNT_W-1:0] sh_per;
   logic             take_now;
   logic             in_window;

   assign wrap     = run && tick && (q >= cur_per);
   assign take_now = !run || sync_off || wrap;

   // shadow copies follow every duty write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_rise <= '0;
         sh_fall <= '0;
         sh_per  <= '0;
      end else if (load) begin
         sh_rise <= new_rise;
         sh_fall <= new_fall;
         sh_per  <= new_per;
      end
   end

   // running copies: immediate when stopped or unsynchronised, else at wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_rise <= '0;
         cur_fall <= '0;
         cur_per  <= '0;
      end else if (take_now) begin
         cur_rise <= load ? new_rise : sh_rise;
         cur_fall <= load ? new_fall : sh_fall;
         cur_per  <= load ? new_per  : sh_per;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (!run) begin
         q <= '0;
      end else if (tick) begin
         q <= wrap ? '0 : (q + CNT_W'(1));
      end
   end

   always_comb begin
      if (cur_rise == cur_fall) begin
         in_window = 1'b1;
      end else if (cur_rise < cur_fall) begin
         in_window = (q >= cur_rise) && (q < cur_fall);
      end else begin
         in_window = (q >= cur_rise) || (q < cur_fall);
      end
   end

   assign level = run && in_window;
endmodule

// File: rtl/qpwm_pin_stage.sv
module qpwm_pin_stage #(
   parameter bit OD_EN = 1'b1
) (
   input  logic level,
   input  logic pin_en,
   input  logic invert,
   input  logic od_mode,
   output logic pin_out,
   output logic pin_oe
);
   logic val;

   assign val = (pin_en & level) ^ invert;

   generate
      if (OD_EN) begin : g_with_od
         assign pin_out = od_mode ? 1'b0 : val;
         assign pin_oe  = od_mode ? ~val : 1'b1;
      end else begin : g_push_pull
         logic unused_od;
         assign unused_od = od_mode;
         assign pin_out   = val;
         assign pin_oe    = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/qpwm_channel.sv
module qpwm_channel #(
   parameter int unsigned LIN_W   = 8,
   parameter int unsigned SHIFT_W = 4,
   parameter int unsigned CNT_W   = 8,
   parameter bit          OD_EN   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        wr_sel,
   input  logic [31:0] wr_data,
   output logic        pin_out,
   output logic        pin_oe
);
   import qpwm_pkg::*;

   generate
      if (LIN_W < 1 || LIN_W > FIELD_SPAN) begin : g_bad_lin
         $error("qpwm_channel: LIN_W must be 1..8");
      end
      if (SHIFT_W > 4) begin : g_bad_shift
         $error("qpwm_channel: SHIFT_W must be 0..4");
      end
      if (CNT_W < 1 || CNT_W > FIELD_SPAN) begin : g_bad_cnt
         $error("qpwm_channel: CNT_W must be 1..8");
      end
   endgenerate

   localparam int unsigned SW = (SHIFT_W == 0) ? 1 : SHIFT_W;

   logic [LIN_W-1:0] div_lin;
   logic [SW-1:0]    div_shift;
   logic             pin_en;
   logic             od_mode;
   logic             invert;
   logic             run;
   logic             sync_off;

   logic             wr_ctrl;
   logic             wr_duty;
   logic             tick;
   logic             wrap;
   logic             level;
   logic [CNT_W-1:0] q;
   logic [CNT_W-1:0] cur_rise;
   logic [CNT_W-1:0] cur_fall;
   logic [CNT_W-1:0] cur_per;

   assign wr_ctrl = wr_en && (qpwm_sel_e'(wr_sel) == SEL_CTRL);
   assign wr_duty = wr_en && (qpwm_sel_e'(wr_sel) == SEL_DUTY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_lin   <= '0;
         div_shift <= '0;
         pin_en    <= 1'b0;
         od_mode   <= 1'b0;
         invert    <= 1'b0;
         run       <= 1'b0;
         sync_off  <= 1'b0;
      end else if (wr_ctrl) begin
         div_lin   <= wr_data[CTL_LIN_LSB +: LIN_W];
         div_shift <= (SHIFT_W == 0) ? '0 : wr_data[CTL_SHIFT_LSB +: SW];
         pin_en    <= wr_data[CTL_PIN_BIT];
         od_mode   <= wr_data[CTL_OD_BIT];
         invert    <= wr_data[CTL_INV_BIT];
         run       <= wr_data[CTL_RUN_BIT];
         sync_off  <= wr_data[CTL_NOSYNC_BIT];
      end
   end

   generate
      if (SHIFT_W == 0) begin : g_ps_lin
         logic unused_shift;
         assign unused_shift = div_shift[0];
         qpwm_prescaler #(.LIN_W(LIN_W), .SHIFT_W(0)) u_ps (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .lin   (div_lin),
            .shift (1'b0),
            .tick  (tick)
         );
      end else begin : g_ps_shift
         qpwm_prescaler #(.LIN_W(LIN_W), .SHIFT_W(SHIFT_W)) u_ps (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .lin   (div_lin),
            .shift (div_shift),
            .tick  (tick)
         );
      end
   endgenerate

   qpwm_period_engine #(.CNT_W(CNT_W)) u_per (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick     (tick),
      .sync_off (sync_off),
      .load     (wr_duty),
      .new_rise (wr_data[DTY_RISE_LSB +: CNT_W]),
      .new_fall (wr_data[DTY_FALL_LSB +: CNT_W]),
      .new_per  (wr_data[DTY_PER_LSB +: CNT_W]),
      .q        (q),
      .cur_rise (cur_rise),
      .cur_fall (cur_fall),
      .cur_per  (cur_per),
      .wrap     (wrap),
      .level    (level)
   );

   qpwm_pin_stage #(.OD_EN(OD_EN)) u_pin (
      .level   (level),
      .pin_en  (pin_en),
      .invert  (invert),
      .od_mode (od_mode),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );
endmodule

// File: rtl/qpwm_checker.sv
module qpwm_checker #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             pin_en,
   input logic             invert,
   input logic             od_mode,
   input logic             sync_off,
   input logic             wrap,
   input logic [CNT_W-1:0] q,
   input logic [CNT_W-1:0] cur_rise,
   input logic [CNT_W-1:0] cur_fall,
   input logic [CNT_W-1:0] cur_per,
   input logic             pin_out,
   input logic             pin_oe
);
   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      od_mode |-> !pin_out); // R10
   AST_PP_ALWAYS_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      !od_mode |-> pin_oe); // R10
   AST_STOPPED_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !od_mode) |-> (pin_out == invert)); // R5
   AST_PIN_OFF_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_en && !od_mode) |-> (pin_out == invert)); // R6
   AST_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (run && pin_en && !od_mode && (cur_rise == cur_fall)) |-> (pin_out == !invert)); // R4
   AST_QUANTUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |->
         ((q == $past(q)) || (q == CNT_W'($past(q) + 1'b1)) || (q == '0))); // R2
   AST_STOPPED_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!run) |-> (q == '0)); // R5
   AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && run && !$past(sync_off) && !$past(wrap)) |->
         ($stable(cur_rise) && $stable(cur_fall) && $stable(cur_per))); // R8
endmodule

bind qpwm_channel qpwm_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .pin_en   (pin_en),
   .invert   (invert),
   .od_mode  (od_mode),
   .sync_off (sync_off),
   .wrap     (wrap),
   .q        (q),
   .cur_rise (cur_rise),
   .cur_fall (cur_fall),
   .cur_per  (cur_per),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe)
);

// File: tb/qpwm_channel_bench.sv
`timescale 1ns/1ps
module qpwm_channel_bench;
   logic        clk;
   logic        rst_n;
   logic        wr_en;
   logic        wr_sel;
   logic [31:0] wr_data;
   logic        pin_out;
   logic        pin_oe;

   int checks;
   int failures;
   bit done;

   typedef struct {
      logic  val;
      logic  oe;
      string tag;
   } exp_t;

   exp_t sbq[$];
   exp_t mon_item;

   qpwm_channel u_qpwm_channel (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic check2(input string tag, input logic a_out, input logic a_oe,
                         input logic e_out, input logic e_oe);
      checks++;
      if (a_out !== e_out || a_oe !== e_oe) begin
         failures++;
         $display("FAIL %s: pin_out=%0b pin_oe=%0b expected pin_out=%0b pin_oe=%0b",
                  tag, a_out, a_oe, e_out, e_oe);
      end
   endtask

   // scoreboard monitor: one expected item per cycle
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sbq.size() != 0) begin
            mon_item = sbq.pop_front();
            check2(mon_item.tag, pin_out, pin_oe, mon_item.val, mon_item.oe);
         end
      end
   end

   function automatic logic [31:0] mk_ctrl(input int lin, input int sh, input bit pin,
                                           input bit od, input bit inv, input bit run,
                                           input bit nosync);
      logic [31:0] w;
      w = '0;
      w[7:0]  = 8'(lin);
      w[11:8] = 4'(sh);
      w[12]   = pin;
      w[13]   = od;
      w[14]   = inv;
      w[16]   = run;
      w[17]   = nosync;
      return w;
   endfunction

   function automatic logic [31:0] mk_duty(input int per, input int fall, input int rise);
      return {8'(per), 8'h00, 8'(fall), 8'(rise)};
   endfunction

   function automatic bit win(input int q, input int r, input int f);
      if (r == f) return 1'b1;
      if (r < f)  return (q >= r) && (q < f);
      return (q >= r) || (q < f);
   endfunction

   // caller stands at a negedge; returns at the next negedge
   task automatic reg_write(input bit sel, input logic [31:0] data);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = data;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic push_wave(input int qlen, input int per, input int r, input int f,
                            input bit inv, input bit pin, input bit od,
                            input int phase0, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         int   qi;
         bit   v;
         qi    = ((phase0 + i) / qlen) % (per + 1);
         v     = (pin & win(qi, r, f)) ^ inv;
         e.val = od ? 1'b0 : v;
         e.oe  = od ? !v : 1'b1;
         e.tag = tag;
         sbq.push_back(e);
      end
   endtask

   task automatic drain();
      while (sbq.size() != 0) @(negedge clk);
   endtask

   // stop, check stopped level, load duty while stopped, then run
   task automatic start_wave(input int lin, input int sh, input int per, input int r,
                             input int f, input bit inv, input bit pin, input bit od,
                             input bit nosync);
      reg_write(1'b0, mk_ctrl(lin, sh, pin, od, inv, 1'b0, nosync));
      check2("R5 stopped level", pin_out, pin_oe, od ? 1'b0 : inv, od ? !inv : 1'b1);
      reg_write(1'b1, mk_duty(per, f, r));
      reg_write(1'b0, mk_ctrl(lin, sh, pin, od, inv, 1'b1, nosync));
   endtask

   initial begin
      #(200000 * 4);
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
   end

   initial begin
      checks   = 0;
      failures = 0;
      done     = 1'b0;
      rst_n    = 1'b0;
      wr_en    = 1'b0;
      wr_sel   = 1'b0;
      wr_data  = '0;
      repeat (3) @(negedge clk);
      check2("R11 reset", pin_out, pin_oe, 1'b0, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check2("R11 after reset", pin_out, pin_oe, 1'b0, 1'b1);

      // R2 R3: quantum 4, 4 quanta, window [0,1); duty loaded while stopped (R5)
      start_wave(1, 1, 3, 0, 1, 1'b0, 1'b1, 1'b0, 1'b0);
      push_wave(4, 3, 0, 1, 1'b0, 1'b1, 1'b0, 0, 32, "R2/R3/R5 basic wave");
      drain();

      // R1: quantum 12 via linear 2 and shift 2
      start_wave(2, 2, 2, 0, 1, 1'b0, 1'b1, 1'b0, 1'b0);
      push_wave(12, 2, 0, 1, 1'b0, 1'b1, 1'b0, 0, 72, "R1 linear+shift quantum");
      drain();

      // R3: wrapped window rise 3 fall 1
      start_wave(1, 0, 4, 3, 1, 1'b0, 1'b1, 1'b0, 1'b0);
      push_wave(2, 4, 3, 1, 1'b0, 1'b1, 1'b0, 0, 30, "R3 wrapped window");
      drain();

      // R4: equal points
      start_wave(1, 0, 3, 2, 2, 1'b0, 1'b1, 1'b0, 1'b0);
      push_wave(2, 3, 2, 2, 1'b0, 1'b1, 1'b0, 0, 16, "R4 full duty");
      drain();
      // R7: invert while running shows next cycle
      reg_write(1'b0, mk_ctrl(1, 0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0));
      check2("R7 immediate invert", pin_out, pin_oe, 1'b0, 1'b1);
      // R5: stop mid period, inactive next cycle (inactive = invert level)
      reg_write(1'b0, mk_ctrl(1, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
      check2("R5 stop mid period", pin_out, pin_oe, 1'b1, 1'b1);

      // R7: inverted wave
      start_wave(0, 0, 3, 1, 3, 1'b1, 1'b1, 1'b0, 1'b0);
      push_wave(1, 3, 1, 3, 1'b1, 1'b1, 1'b0, 0, 16, "R7 inverted wave");
      drain();

      // R6: pin enable clear, both polarities
      start_wave(0, 0, 3, 0, 2, 1'b0, 1'b0, 1'b0, 1'b0);
      push_wave(1, 3, 0, 2, 1'b0, 1'b0, 1'b0, 0, 12, "R6 pin off normal");
      drain();
      start_wave(0, 0, 3, 0, 2, 1'b1, 1'b0, 1'b0, 1'b0);
      push_wave(1, 3, 0, 2, 1'b1, 1'b0, 1'b0, 0, 12, "R6 pin off inverted");
      drain();

      // R10: open drain, both polarities
      start_wave(0, 0, 3, 0, 2, 1'b0, 1'b1, 1'b1, 1'b0);
      push_wave(1, 3, 0, 2, 1'b0, 1'b1, 1'b1, 0, 16, "R10 open drain");
      drain();
      start_wave(0, 0, 3, 0, 2, 1'b1, 1'b1, 1'b1, 1'b0);
      push_wave(1, 3, 0, 2, 1'b1, 1'b1, 1'b1, 0, 16, "R10 open drain inverted");
      drain();

      // R8: synchronised mid-period writes, quantum 1
      start_wave(0, 0, 7, 0, 4, 1'b0, 1'b1, 1'b0, 1'b0);
      push_wave(1, 7, 0, 4, 1'b0, 1'b1, 1'b0, 0, 8, "R8 before wrap");
      push_wave(1, 7, 0, 6, 1'b0, 1'b1, 1'b0, 8, 8, "R8 new fall after wrap");
      push_wave(1, 3, 0, 2, 1'b0, 1'b1, 1'b0, 0, 16, "R8 new period after wrap");
      repeat (2) @(negedge clk);
      reg_write(1'b1, mk_duty(7, 6, 0));
      repeat (7) @(negedge clk);
      reg_write(1'b1, mk_duty(3, 2, 0));
      drain();

      // R9: unsynchronised writes apply next cycle
      start_wave(0, 0, 7, 0, 4, 1'b0, 1'b1, 1'b0, 1'b1);
      push_wave(1, 7, 0, 4, 1'b0, 1'b1, 1'b0, 0, 3, "R9 before write");
      push_wave(1, 7, 0, 6, 1'b0, 1'b1, 1'b0, 3, 8, "R9 fall 6 at once");
      push_wave(1, 7, 0, 2, 1'b0, 1'b1, 1'b0, 11, 13, "R9 fall 2 at once");
      repeat (2) @(negedge clk);
      reg_write(1'b1, mk_duty(7, 6, 0));
      repeat (7) @(negedge clk);
      reg_write(1'b1, mk_duty(7, 2, 0));
      drain();

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule